// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital sequencing logic placed beside a successive-approximation converter. It decides when a conversion runs and how long it lasts. It also decides which channel the analog multiplexer sees and when a finished result may enter the two result bytes. The analog conversion itself is modelled as a fixed count of prescaled converter clock ticks. At the end of that count, the word presented on `sample_in` is captured.

Software programs the block through a four-register byte interface. A conversion can begin in three ways: a direct start command, a rising edge on one of seven external trigger lines (picked by a 3-bit source field), or free-running operation. In free-running operation, each completion immediately launches the next conversion. The result sits in a low byte and a high byte. Reading the low byte freezes both bytes until the high byte is read, so the two halves always belong to the same sample.

Top module: `adc_seq`

## Requirements
- R1: Writing CTRL (address 0) with bit 0 set, while idle and with power-down clear, starts a conversion. CTRL bit 0 and `conv_busy` read 1 for exactly 13 prescaled ticks and return to 0 when the conversion ends.
- R2: The tick divider is 2^(s+1) system clocks, where s is CTRL bits 6:4, and it saturates at 128. A conversion therefore lasts 13·2^(s+1) clocks from the write edge.
- R3: While the power-down bit (CFG address 1, bit 3) is 1, neither a start write nor a trigger edge begins a conversion.
- R4: With auto-trigger on (CTRL bit 1), a rising edge on `trig_in[k]` starts a conversion when k equals the source field in CFG bits 2:0. Edges on any other line have no effect.
- R5: A trigger edge that arrives during a conversion neither restarts nor prolongs it. A trigger that is still high when the conversion ends does not start a new one; a fresh rising edge is needed.
- R6: The completion flag (CTRL bit 2) is set at the end of every conversion, whatever the interrupt enable (CTRL bit 3) holds. Writing 1 to bit 2 clears it. `irq` is high exactly when both the flag and the enable are 1.
- R7: Source value 7 selects free-running mode. With auto-trigger on, the first conversion needs a start write. Each later conversion follows the previous one with no idle cycle, whether or not the flag was cleared. Turning auto-trigger off lets the current conversion end without a successor.
- R8: `chan_sel` follows the channel field (CFG bits 7:4) while idle. A channel write during a conversion reaches `chan_sel` only when that conversion ends.
- R9: Reading the low result byte (address 2) locks both result bytes. A conversion that ends while they are locked changes neither byte, but it still sets the flag.
- R10: Reading the high result byte (address 3) removes the lock, and the next completion loads both bytes. Address 2 returns result bits 7:0; address 3 returns result bits 9:8 in its low two bits and zeros above them.
- R11: After reset, CTRL and CFG read 0, `conv_busy`, `irq` and `chan_sel` are 0, and no conversion runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the result lock) |
| addr | input | 2 | Register address: 0 CTRL, 1 CFG, 2 result low, 3 result high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| trig_in | input | 7 | External trigger lines |
| sample_in | input | 10 | Converter output word, captured at completion |
| chan_sel | output | 4 | Channel applied to the analog multiplexer |
| conv_busy | output | 1 | High while a conversion runs |
| irq | output | 1 | Completion interrupt request |

## Verification
An internal fault in this block appears at the ports within one conversion time. A miscounting prescaler or tick counter moves the falling edge of `conv_busy` away from 13·2^(s+1) clocks. A bad edge detector or busy gate shows up as a conversion that starts when it should not, or fails to start, one clock after the stimulus. A lock register stuck in either state shows up as wrong result bytes on the first read after a completion that should have been blocked or kept. Changing the channel mid-conversion shows the hold on `chan_sel` one clock after the write.

// File: rtl/adc_seq_pkg.sv
// Package: shared register addresses and bit positions for the ADC sequencer.
// Assumes a 2-bit register address space and 8-bit data.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CFG  = 2'd1,
        REG_RLO  = 2'd2,
        REG_RHI  = 2'd3
    } reg_addr_e;

    // CTRL bit positions
    localparam int CTRL_START = 0;
    localparam int CTRL_AUTO  = 1;
    localparam int CTRL_FLAG  = 2;
    localparam int CTRL_IEN   = 3;
    localparam int CTRL_PSEL  = 4;

    // CFG bit positions
    localparam int CFG_SRC    = 0;
    localparam int CFG_PDOWN  = 3;
    localparam int CFG_CHAN   = 4;

    // Source-select value that means free-running
    localparam logic [2:0] SRC_FREE = 3'd7;

endpackage

// File: rtl/adc_seq_timer.sv
// Conversion timer: divides the system clock down to converter ticks and
// counts CONV_TICKS of them. Counters are held at zero while run is low,
// so each conversion starts from a cleared prescaler. done pulses for
// one clock on the last tick. Assumes psel may change only between runs.
module adc_seq_timer #(
    parameter int CONV_TICKS = 13,
    parameter int PSEL_W     = 3,
    parameter int MAX_LOG2   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSEL_W-1:0] psel,
    output logic              done
);
    localparam int TICK_W = $clog2(CONV_TICKS);
    localparam int PRE_W  = MAX_LOG2;

    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  div_m1;
    logic [TICK_W-1:0] tick_q;
    logic              tick;

    // Divider terminal count from the select field, saturated at 2^MAX_LOG2.
    always_comb begin
        if (int'(psel) + 1 >= MAX_LOG2)
            div_m1 = '1;
        else
            div_m1 = PRE_W'((1 << (int'(psel) + 1)) - 1);
    end

    assign tick = run && (pre_q >= div_m1);
    assign done = tick && (tick_q == TICK_W'(CONV_TICKS - 1));

    // Prescaler and tick counter, cleared whenever no conversion runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (tick) begin
            pre_q  <= '0;
            tick_q <= done ? '0 : tick_q + 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_trig.sv
// Trigger selector: picks one external line by the source field and
// reports its rising edge. Source values at or above TRIG_N select a
// constant low, so they never produce an edge.
module adc_seq_trig #(
    parameter int TRIG_N = 7,
    parameter int SRC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIG_N-1:0] trig_in,
    input  logic [SRC_W-1:0]  src,
    output logic              rise
);
    localparam int SRC_N = 1 << SRC_W;

    logic [SRC_N-1:0] padded;
    logic             sel_now;
    logic             sel_prev;

    assign padded  = SRC_N'(trig_in);
    assign sel_now = padded[src];
    assign rise    = sel_now && !sel_prev;

    // Remember the selected line's previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_prev <= 1'b0;
        else
            sel_prev <= sel_now;
    end
endmodule

// File: rtl/adc_seq_result.sv
// Result holder: captures the converter word on load unless locked.
// A low-byte read sets the lock and a high-byte read clears it; the high
// read wins when both strobes arrive together.
module adc_seq_result #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] sample,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [RES_W-1:0] res,
    output logic             locked
);
    // Capture a finished conversion when the bytes are not locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res <= '0;
        else if (load && !locked)
            res <= sample;
    end

    // Track the split-read lock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (rd_hi)
            locked <= 1'b0;
        else if (rd_lo)
            locked <= 1'b1;
    end
endmodule

// File: rtl/adc_seq.sv
// ADC conversion sequencer top. It holds the control and configuration
// registers and decides when a conversion starts (start write, external
// edge, or free-running restart). It drives the channel select, the
// completion flag and the interrupt request. Assumes RES_W is 9 to 16 and
// TRIG_N is below 2^SRC_W, so the top source value stays free for
// free-running.
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int CHAN_W     = 4,
    parameter int TRIG_N     = 7,
    parameter int CONV_TICKS = 13,
    parameter int MAX_LOG2   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [TRIG_N-1:0] trig_in,
    input  logic [RES_W-1:0]  sample_in,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              conv_busy,
    output logic              irq
);
    localparam int PSEL_W = 3;
    localparam int SRC_W  = 3;

    logic              busy_q;
    logic              auto_q;
    logic              flag_q;
    logic              ien_q;
    logic [PSEL_W-1:0] psel_q;
    logic [SRC_W-1:0]  src_q;
    logic              pdown_q;
    logic [CHAN_W-1:0] chan_req_q;
    logic [CHAN_W-1:0] chan_act_q;
    logic [RES_W-1:0]  res_q;
    logic              res_locked;

    logic wr_ctrl, wr_cfg, rd_lo, rd_hi;
    logic conv_done, trig_rise;
    logic start_sw, start_trig, restart_free;

    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_cfg  = wr_en && (addr == REG_CFG);
    assign rd_lo   = rd_en && (addr == REG_RLO);
    assign rd_hi   = rd_en && (addr == REG_RHI);

    adc_seq_timer #(
        .CONV_TICKS (CONV_TICKS),
        .PSEL_W     (PSEL_W),
        .MAX_LOG2   (MAX_LOG2)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_q),
        .psel  (psel_q),
        .done  (conv_done)
    );

    adc_seq_trig #(
        .TRIG_N (TRIG_N),
        .SRC_W  (SRC_W)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .src     (src_q),
        .rise    (trig_rise)
    );

    adc_seq_result #(
        .RES_W (RES_W)
    ) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (conv_done),
        .sample (sample_in),
        .rd_lo  (rd_lo),
        .rd_hi  (rd_hi),
        .res    (res_q),
        .locked (res_locked)
    );

    assign start_sw     = wr_ctrl && wdata[CTRL_START] && !pdown_q && !busy_q;
    assign start_trig   = auto_q && (src_q != SRC_FREE) && trig_rise && !pdown_q && !busy_q;
    assign restart_free = conv_done && auto_q && (src_q == SRC_FREE) && !pdown_q;

    // Conversion-in-progress state: set on any start, cleared on a final completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (start_sw || start_trig)
            busy_q <= 1'b1;
        else if (conv_done && !restart_free)
            busy_q <= 1'b0;
    end

    // Completion flag: set by hardware, cleared by writing 1; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (conv_done)
            flag_q <= 1'b1;
        else if (wr_ctrl && wdata[CTRL_FLAG])
            flag_q <= 1'b0;
    end

    // Control fields written through CTRL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
            ien_q  <= 1'b0;
            psel_q <= '0;
        end else if (wr_ctrl) begin
            auto_q <= wdata[CTRL_AUTO];
            ien_q  <= wdata[CTRL_IEN];
            psel_q <= wdata[CTRL_PSEL +: PSEL_W];
        end
    end

    // Configuration fields written through CFG.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q      <= '0;
            pdown_q    <= 1'b0;
            chan_req_q <= '0;
        end else if (wr_cfg) begin
            src_q      <= wdata[CFG_SRC +: SRC_W];
            pdown_q    <= wdata[CFG_PDOWN];
            chan_req_q <= wdata[CFG_CHAN +: CHAN_W];
        end
    end

    // Applied channel follows the request only between conversions.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan_act_q <= '0;
        else if (!busy_q || conv_done)
            chan_act_q <= chan_req_q;
    end

    // Register read multiplexer.
    always_comb begin
        unique case (addr)
            REG_CTRL: rdata = {1'b0, psel_q, ien_q, flag_q, auto_q, busy_q};
            REG_CFG:  rdata = {chan_req_q, pdown_q, src_q};
            REG_RLO:  rdata = res_q[7:0];
            REG_RHI:  rdata = 8'(res_q[RES_W-1:8]);
            default:  rdata = '0;
        endcase
    end

    assign chan_sel  = chan_act_q;
    assign conv_busy = busy_q;
    assign irq       = flag_q && ien_q;
endmodule

// File: rtl/adc_seq_chk.sv
// Checker for adc_seq: temporal properties over ports and internal state,
// attached with bind. Assumes the default CTRL/CFG bit layout.
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int CHAN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [7:0]        wdata,
    input logic              busy,
    input logic              pdown,
    input logic              flag,
    input logic              conv_done,
    input logic [CHAN_W-1:0] chan_sel,
    input logic              res_locked,
    input logic [RES_W-1:0]  res_q
);
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTRL && wdata[CTRL_START] && !pdown && !busy) |=> busy); // R1

    AST_PDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pdown && !busy) |=> !busy); // R3

    AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> flag); // R6

    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> $stable(chan_sel)); // R8

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        res_locked |=> $stable(res_q)); // R9
endmodule

bind adc_seq adc_seq_chk #(
    .RES_W  (RES_W),
    .CHAN_W (CHAN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .busy       (busy_q),
    .pdown      (pdown_q),
    .flag       (flag_q),
    .conv_done  (conv_done),
    .chan_sel   (chan_act_q),
    .res_locked (res_locked),
    .res_q      (res_q)
);

// File: tb/adc_seq_test.sv
module adc_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [6:0] trig_in = 7'd0;
    logic [9:0] sample_in = 10'd0;
    logic [3:0] chan_sel;
    logic       conv_busy;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    adc_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .trig_in(trig_in), .sample_in(sample_in),
        .chan_sel(chan_sel), .conv_busy(conv_busy), .irq(irq)
    );

    localparam int NVEC = 4;
    localparam logic [2:0] VPSEL [NVEC] = '{3'd0, 3'd1, 3'd3, 3'd7};
    localparam logic [9:0] VSAMP [NVEC] = '{10'h3A5, 10'h012, 10'h2FF, 10'h100};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (conv_busy) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        peek(2'd0, d); chk("R11 ctrl", d, 0);
        peek(2'd1, d); chk("R11 cfg", d, 0);
        chk("R11 busy", conv_busy, 0);
        chk("R11 irq", irq, 0);
        chk("R11 chan", chan_sel, 0);

        // R1/R2/R10 vector table: one conversion per divider setting
        for (int i = 0; i < NVEC; i++) begin
            int div;
            div = (VPSEL[i] >= 3'd6) ? 128 : (2 << VPSEL[i]);
            sample_in = VSAMP[i];
            wr(2'd0, {1'b0, VPSEL[i], 4'b0101});
            count_busy(n);
            chk("R1 R2 conversion length", n, 13 * div);
            peek(2'd0, d); chk("R6 flag after completion", d[2], 1);
            rd(2'd2, d); chk("R10 low byte", d, VSAMP[i][7:0]);
            rd(2'd3, d); chk("R10 high byte", d, {6'd0, VSAMP[i][9:8]});
        end

        // R6 flag, enable and interrupt
        chk("R6 irq with enable off", irq, 0);
        wr(2'd0, 8'h08);
        chk("R6 irq with enable on", irq, 1);
        wr(2'd0, 8'h0C);
        chk("R6 irq after clear", irq, 0);
        peek(2'd0, d); chk("R6 flag cleared", d[2], 0);
        wr(2'd0, 8'h00);

        // R3 power-down blocks start and triggers
        wr(2'd1, 8'h09);
        wr(2'd0, 8'h01);
        idle(3); chk("R3 start blocked", conv_busy, 0);
        wr(2'd0, 8'h02);
        @(negedge clk) trig_in[1] = 1'b1;
        idle(3); chk("R3 trigger blocked", conv_busy, 0);
        trig_in[1] = 1'b0;
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);

        // R4 source selection
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h02);
        @(negedge clk) trig_in[3] = 1'b1;
        idle(3); chk("R4 other source ignored", conv_busy, 0);
        trig_in[3] = 1'b0;
        trig_in[2] = 1'b1;
        @(negedge clk); chk("R4 selected edge starts", conv_busy, 1);
        // R5 edge during busy ignored, high at end does not restart
        n = 0;
        while (conv_busy) begin
            if (n == 3) trig_in[2] = 1'b0;
            if (n == 10) trig_in[2] = 1'b1;
            @(negedge clk);
            n++;
        end
        chk("R5 length unaffected by mid edge", n, 26);
        idle(5); chk("R5 held trigger no restart", conv_busy, 0);
        trig_in[2] = 1'b0;
        @(negedge clk) trig_in[2] = 1'b1;
        @(negedge clk); chk("R5 fresh edge starts", conv_busy, 1);
        trig_in[2] = 1'b0;
        count_busy(n);
        wr(2'd0, 8'h04);

        // R7 free-running
        sample_in = 10'h155;
        wr(2'd1, 8'h07);
        idle(3); chk("R7 no start without write", conv_busy, 0);
        wr(2'd0, 8'h03);
        idle(30);
        peek(2'd0, d); chk("R7 running after first end", d[2:0], 3'b111);
        idle(26);
        chk("R7 back to back with flag set", conv_busy, 1);
        rd(2'd2, d); chk("R7 result loaded", d, 8'h55);
        rd(2'd3, d);
        wr(2'd0, 8'h04);
        idle(30);
        chk("R7 stops when auto off", conv_busy, 0);

        // R8 channel hold
        wr(2'd1, 8'h20);
        @(negedge clk); chk("R8 channel while idle", chan_sel, 2);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h50);
        @(negedge clk); chk("R8 channel held during conversion", chan_sel, 2);
        count_busy(n);
        @(negedge clk); chk("R8 channel after end", chan_sel, 5);
        wr(2'd0, 8'h04);

        // R9/R10 split-read lock
        sample_in = 10'h2AB;
        wr(2'd0, 8'h01);
        count_busy(n);
        sample_in = 10'h1CD;
        wr(2'd0, 8'h05);
        rd(2'd2, d); chk("R9 low read before end", d, 8'hAB);
        count_busy(n);
        peek(2'd0, d); chk("R9 flag set despite lock", d[2], 1);
        rd(2'd2, d); chk("R9 low byte kept", d, 8'hAB);
        rd(2'd3, d); chk("R9 high byte kept", d, 8'h02);
        wr(2'd0, 8'h05);
        count_busy(n);
        rd(2'd2, d); chk("R10 low after unlock", d, 8'hCD);
        rd(2'd3, d); chk("R10 high after unlock", d, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule